// File: doc/BRIEF.md
# Quad DAC Serial Command Receiver

This block is the digital front end of a four-channel 8-bit DAC. It watches a three-wire serial port (serial clock, serial data, commit strobe) and a separate update strobe. All four lines are oversampled in a fast system clock domain. Command words are shifted in one bit per falling edge of the serial clock.

Each complete command carries a channel address, a gain select and an output code. A falling edge on the commit strobe writes the command into the staging register of the addressed channel. A falling edge on the update strobe then copies all four staging registers into the output registers at once, so every channel changes in the same cycle.

A commit that arrives without exactly one full command pending is rejected. It leaves every register as it was and raises a one-cycle error pulse. Analog conversion and reference generation belong elsewhere.

Top module: `qdac_cmd_rx`

## Requirements
- R1: A command word is 11 bits long and is sent MSB first. Its first two bits address the channel: 00 is channel 0, 01 is channel 1, 10 is channel 2 and 11 is channel 3. Channel c drives `out_code_o[c*8 +: 8]` and `out_gain_o[c]`.
- R2: The third bit of a command selects the gain. A 1 (x2) gives a gain output of 1, and a 0 (x1) gives a gain output of 0.
- R3: The last eight bits of a command form the unsigned output code, MSB first.
- R4: A data bit is taken only on a high-to-low transition of `sclk_i`. A rising edge shifts nothing.
- R5: A high-to-low transition of `commit_i` with exactly 11 bits received writes the command into the staging register of the addressed channel. It raises no error, and the outputs do not change because of it.
- R6: A high-to-low transition of `update_i` copies the code and gain of all four staging registers into the output registers in one system cycle. At no other time do the outputs change, apart from reset.
- R7: A high-to-low transition of `commit_i` with fewer than 11 bits received discards the bits and leaves all registers unchanged. `frame_err_o` is then high for exactly one cycle.
- R8: When more than 11 bits arrive before a commit, only the last 11 are used.
- R9: The bit count returns to zero after every commit edge, so a second commit with no new bits is a frame error.
- R10: A synchronous active-high `rst` clears the staging registers, the output registers, the bit count and `frame_err_o`.
- R11: Each external line passes through `SYNC_STAGES` flops before edge detection. An action takes effect at the output `SYNC_STAGES`+1 system clocks after the line changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Serial clock; data is taken on its falling edge |
| sdat_i | input | 1 | Serial data, MSB first |
| commit_i | input | 1 | Commit strobe, active on its falling edge |
| update_i | input | 1 | Output update strobe, active on its falling edge |
| out_code_o | output | 32 | Four 8-bit output codes, channel 0 in the low byte |
| out_gain_o | output | 4 | Gain select per channel, 1 means x2 |
| frame_err_o | output | 1 | One-cycle pulse on a rejected commit |

## Verification
The bench builds the block with its default parameters: 8-bit codes, a 2-bit address (four channels) and a two-stage synchronizer. With these values the 11-bit word boundary can be reached exactly, and so can a short word, an overlong word and a commit with nothing pending. Every line is held for four system clocks per phase, which is longer than the three-flop path from pin to register. This lets the bench sample a settled result in a known cycle.

// File: rtl/qdac_cmd_rx.sv
module qdac_cmd_rx #(
  parameter int CODE_W      = 8,
  parameter int ADDR_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             sclk_i,
  input  logic                             sdat_i,
  input  logic                             commit_i,
  input  logic                             update_i,
  output logic [(CODE_W<<ADDR_W)-1:0]      out_code_o,
  output logic [(1<<ADDR_W)-1:0]           out_gain_o,
  output logic                             frame_err_o
);
  localparam int NCH   = 1 << ADDR_W;
  localparam int CMD_W = ADDR_W + 1 + CODE_W;
  localparam int CNT_W = $clog2(CMD_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(CMD_W);

  logic [3:0]             stg [SYNC_STAGES];
  logic [3:0]             last_q;
  logic [3:0]             pins_s, fall;
  logic                   sclk_fall, commit_fall, upd_fall, dat;
  logic [CMD_W-1:0]       shreg;
  logic [CNT_W-1:0]       bit_cnt;
  logic [ADDR_W-1:0]      addr;
  logic [NCH*CODE_W-1:0]  in_code;
  logic [NCH-1:0]         in_gain;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < SYNC_STAGES; i++) stg[i] <= '0;
      last_q <= '0;
    end else begin
      stg[0] <= {update_i, commit_i, sdat_i, sclk_i};
      for (int i = 1; i < SYNC_STAGES; i++) stg[i] <= stg[i-1];
      last_q <= stg[SYNC_STAGES-1];
    end
  end

  assign pins_s      = stg[SYNC_STAGES-1];
  assign fall        = last_q & ~pins_s;
  assign sclk_fall   = fall[0];
  assign dat         = pins_s[1];
  assign commit_fall = fall[2];
  assign upd_fall    = fall[3];
  assign addr        = shreg[CMD_W-1 -: ADDR_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg       <= '0;
      bit_cnt     <= '0;
      in_code     <= '0;
      in_gain     <= '0;
      frame_err_o <= 1'b0;
    end else begin
      frame_err_o <= 1'b0;
      if (commit_fall) begin
        bit_cnt <= '0;
        if (bit_cnt == FULL) begin
          in_code[addr*CODE_W +: CODE_W] <= shreg[CODE_W-1:0];
          in_gain[addr]                  <= shreg[CODE_W];
        end else begin
          frame_err_o <= 1'b1;
        end
      end else if (sclk_fall) begin
        shreg <= {shreg[CMD_W-2:0], dat};
        if (bit_cnt != FULL) bit_cnt <= bit_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_code_o <= '0;
      out_gain_o <= '0;
    end else if (upd_fall) begin
      out_code_o <= in_code;
      out_gain_o <= in_gain;
    end
  end
endmodule

// File: rtl/qdac_cmd_rx_chk.sv
module qdac_cmd_rx_chk #(
  parameter int CODE_W = 8,
  parameter int NCH    = 4,
  parameter int CMD_W  = 11,
  parameter int CNT_W  = 4
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    commit_fall,
  input logic                    upd_fall,
  input logic [CNT_W-1:0]        bit_cnt,
  input logic                    frame_err_o,
  input logic [NCH*CODE_W-1:0]   out_code_o,
  input logic [NCH-1:0]          out_gain_o
);
  // R7
  err_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    frame_err_o |=> !frame_err_o);

  // R7
  short_err_chk: assert property (@(posedge clk) disable iff (rst)
    (commit_fall && bit_cnt != CNT_W'(CMD_W)) |=> frame_err_o);

  // R5
  full_ok_chk: assert property (@(posedge clk) disable iff (rst)
    (commit_fall && bit_cnt == CNT_W'(CMD_W)) |=> !frame_err_o);

  // R9
  cnt_clear_chk: assert property (@(posedge clk) disable iff (rst)
    commit_fall |=> bit_cnt == '0);

  // R8
  cnt_sat_chk: assert property (@(posedge clk) disable iff (rst)
    bit_cnt <= CNT_W'(CMD_W));

  // R6
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !upd_fall |=> ($stable(out_code_o) && $stable(out_gain_o)));

  // R10
  rst_clear_chk: assert property (@(posedge clk)
    rst |=> (out_code_o == '0 && out_gain_o == '0 && !frame_err_o && bit_cnt == '0));
endmodule

bind qdac_cmd_rx qdac_cmd_rx_chk #(
  .CODE_W(CODE_W), .NCH(NCH), .CMD_W(CMD_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .commit_fall(commit_fall), .upd_fall(upd_fall),
  .bit_cnt(bit_cnt), .frame_err_o(frame_err_o),
  .out_code_o(out_code_o), .out_gain_o(out_gain_o)
);

// File: tb/qdac_cmd_rx_bench.sv
`timescale 1ns/1ps
module qdac_cmd_rx_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sclk = 1'b0, sdat = 1'b0, commit = 1'b0, update = 1'b0;
  logic [31:0] out_code;
  logic [3:0]  out_gain;
  logic        frame_err;

  int tests = 0, fails = 0, err_pulses = 0;
  bit done = 1'b0;

  logic [7:0] exp_in_code [4];
  logic [3:0] exp_in_gain;
  logic [31:0] exp_code;
  logic [3:0]  exp_gain;

  always #2.5 clk = ~clk;

  qdac_cmd_rx u_qdac_cmd_rx (
    .clk(clk), .rst(rst), .sclk_i(sclk), .sdat_i(sdat),
    .commit_i(commit), .update_i(update),
    .out_code_o(out_code), .out_gain_o(out_gain), .frame_err_o(frame_err)
  );

  always @(posedge clk) if (!rst && frame_err) err_pulses++;

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_outs(string req);
    check(out_code === exp_code, req, out_code, exp_code);
    check(out_gain === exp_gain, req, {28'd0, out_gain}, {28'd0, exp_gain});
  endtask

  task automatic send_bits(logic [31:0] bits, int n);
    for (int i = n - 1; i >= 0; i--) begin
      sdat = bits[i];
      sclk = 1'b1;
      wait_n(4);
      sclk = 1'b0;
      wait_n(4);
    end
  endtask

  task automatic do_commit();
    commit = 1'b1; wait_n(4);
    commit = 1'b0; wait_n(6);
  endtask

  task automatic do_update();
    update = 1'b1; wait_n(4);
    update = 1'b0; wait_n(6);
    for (int c = 0; c < 4; c++) exp_code[c*8 +: 8] = exp_in_code[c];
    exp_gain = exp_in_gain;
  endtask

  task automatic write_cmd(logic [1:0] ch, logic g, logic [7:0] code);
    send_bits({21'd0, ch, g, code}, 11);
    do_commit();
    exp_in_code[ch] = code;
    exp_in_gain[ch] = g;
  endtask

  task automatic clear_model();
    for (int c = 0; c < 4; c++) exp_in_code[c] = 8'h00;
    exp_in_gain = '0;
    exp_code = '0;
    exp_gain = '0;
  endtask

  task automatic t_reset();
    rst = 1'b1; wait_n(4); rst = 1'b0; wait_n(2);
    clear_model();
    check_outs("R10 reset outputs");
    check(frame_err === 1'b0, "R10 reset err", {31'd0, frame_err}, 32'd0);
  endtask

  task automatic t_single();
    int e0 = err_pulses;
    write_cmd(2'b01, 1'b1, 8'hA5);
    check_outs("R5 outputs held before update");
    check(err_pulses == e0, "R5 no error on full word", err_pulses, e0);
    do_update();
    check(out_code[15:8] === 8'hA5, "R3 code of channel 1", {24'd0, out_code[15:8]}, 32'hA5);
    check(out_gain[1] === 1'b1, "R2 gain x2", {31'd0, out_gain[1]}, 32'd1);
    check_outs("R1 only channel 1 written");
  endtask

  task automatic t_all_channels();
    write_cmd(2'b00, 1'b0, 8'h11);
    write_cmd(2'b01, 1'b0, 8'h80);
    write_cmd(2'b10, 1'b1, 8'h3C);
    write_cmd(2'b11, 1'b1, 8'hFF);
    check_outs("R6 no change before update");
    do_update();
    check(out_code === 32'hFF3C8011, "R1 R6 all channels at once", out_code, 32'hFF3C8011);
    check(out_gain === 4'b1100, "R2 gain per channel", {28'd0, out_gain}, 32'hC);
  endtask

  task automatic t_short();
    int e0 = err_pulses;
    send_bits(32'h07, 7);
    do_commit();
    check(err_pulses == e0 + 1, "R7 one error pulse on short word", err_pulses, e0 + 1);
    do_update();
    check_outs("R7 short word discarded");
  endtask

  task automatic t_long();
    int e0 = err_pulses;
    send_bits({18'd0, 3'b111, 2'b10, 1'b0, 8'h5A}, 14);
    do_commit();
    exp_in_code[2] = 8'h5A;
    exp_in_gain[2] = 1'b0;
    check(err_pulses == e0, "R8 long word accepted", err_pulses, e0);
    do_update();
    check_outs("R8 last 11 bits used");
  endtask

  task automatic t_cnt_clear();
    int e0 = err_pulses;
    write_cmd(2'b00, 1'b1, 8'h42);
    do_commit();
    check(err_pulses == e0 + 1, "R9 repeat commit is error", err_pulses, e0 + 1);
    do_update();
    check_outs("R9 first write kept");
  endtask

  task automatic t_rising_only();
    int e0 = err_pulses;
    send_bits({21'd0, 2'b11, 1'b0, 8'h96}, 11);
    sdat = 1'b1; sclk = 1'b1; wait_n(6);
    do_commit();
    sclk = 1'b0; wait_n(4);
    exp_in_code[3] = 8'h96;
    exp_in_gain[3] = 1'b0;
    check(err_pulses == e0, "R4 rising edge shifts nothing", err_pulses, e0);
    do_update();
    check_outs("R4 word intact after rising edge");
  endtask

  task automatic t_latency();
    exp_in_code[1] = 8'hC3;
    exp_in_gain[1] = 1'b0;
    send_bits({21'd0, 2'b01, 1'b0, 8'hC3}, 11);
    do_commit();
    update = 1'b1; wait_n(4);
    update = 1'b0;
    wait_n(2);
    check(out_code[15:8] !== 8'hC3, "R11 no change after two clocks", {24'd0, out_code[15:8]}, 32'hC3);
    wait_n(1);
    check(out_code[15:8] === 8'hC3, "R11 change after three clocks", {24'd0, out_code[15:8]}, 32'hC3);
    wait_n(4);
    for (int c = 0; c < 4; c++) exp_code[c*8 +: 8] = exp_in_code[c];
    exp_gain = exp_in_gain;
  endtask

  initial begin
    wait_n(2);
    t_reset();
    t_single();
    t_all_channels();
    t_short();
    t_long();
    t_cnt_clear();
    t_rising_only();
    t_latency();
    t_reset();
    do_update();
    check_outs("R10 staging cleared by reset");
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule